// File: doc/BRIEF.md
# Pixel Cluster Centroid Unit

This block reduces one pixel cluster to one summary word. A cluster arrives on a valid/ready input stream as zero or more hit words, followed by one closing word. Each hit word carries a column and row offset, in two's complement, measured from the cluster's reference pixel. The closing word carries the reference pixel's absolute column and row. The reference pixel is itself part of the cluster.

The block keeps the smallest and largest offset on each axis. When the closing word arrives, it turns the extreme pixels into absolute indices. It then converts those indices into pixel-centre positions in integer normalized units: 25 µm per unit across columns and 5 µm per unit across rows. A normal column pixel is 16 units wide. The first and last column of each front-end chip are 24 units wide. Each row pixel is 10 units tall. The output word carries the bounding-box centre on both axes and the cluster extent in pixels on both axes. It waits in a single output register until the consumer takes it.

Top module: `cc_centroid_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each accepted word with `in_last`=1 produces exactly one output word, visible on `out_valid` one cycle after acceptance. A word with `in_last`=0 produces no output.
- R3: Column index c sits in chip c / COLS_PER_FE at position k = c % COLS_PER_FE. A pixel is 24 units wide when k is 0 or COLS_PER_FE-1 and 16 units wide otherwise, laid out with no gaps from column 0. Its centre is its start plus half its width. `out_ctr_col` = (centre of the lowest column + centre of the highest column) / 2.
- R4: Row centre = 10·r + 5. `out_ctr_row` = (centre of the lowest row + centre of the highest row) / 2.
- R5: `out_size_col` and `out_size_row` each equal (highest index − lowest index + 1).
- R6: The reference pixel always counts. A cluster made of only a closing word reports size 1 on both axes and the reference pixel's own centres.
- R7: Hit offsets are two's complement and are added to the reference coordinates. Negative offsets extend the box below the reference.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and every output field holds its value.
- R9: Extremes are cleared when a cluster closes, so no hit of one cluster changes the result of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_last | input | 1 | 1 = closing word with absolute reference, 0 = hit word with offsets |
| in_col | input | COL_W (8) | Column offset (hit) or absolute column (closing word) |
| in_row | input | ROW_W (9) | Row offset (hit) or absolute row (closing word) |
| out_valid | output | 1 | Summary word valid |
| out_ready | input | 1 | Consumer accepts the summary word |
| out_ctr_col | output | NC_W (12) | Column centroid in 25 µm units |
| out_ctr_row | output | NR_W (12) | Row centroid in 5 µm units |
| out_size_col | output | COL_W+1 (9) | Cluster extent in columns |
| out_size_row | output | ROW_W+1 (10) | Cluster extent in rows |

## Verification
A wrong extreme register does not show at once. It appears only in the next summary word, as a wrong size or a wrong centroid, one cycle after the closing word. If the clear is missing, the error leaks into the following cluster instead. A mistake in the chip-edge column map shows up as a centroid off by 4 or 8 units only for clusters that touch a chip boundary, so the stimulus deliberately includes clusters that straddle those boundaries. A fault in the handshake state shows up in the very same cycle, as a moved output field or a raised `in_ready` during a stall.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
// Package cc_pkg: geometry constants in normalized units (25 um per column
// unit, 5 um per row unit) shared by the centroid unit modules.
package cc_pkg;
    localparam int STD_SPAN  = 16;  // normal column pixel, 400 um
    localparam int EDGE_SPAN = 24;  // chip-edge column pixel, 600 um
    localparam int ROW_SPAN  = 10;  // row pixel, 50 um
endpackage

// File: rtl/cc_extent_track.sv
`timescale 1ns/1ps
// Module cc_extent_track: keeps the smallest and largest signed offset seen
// on one axis during a cluster. The outputs always include offset zero (the
// reference pixel). Assumes hit_en and clr are never high together.
module cc_extent_track #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_en,
    input  logic                clr,
    input  logic signed [W-1:0] val,
    output logic signed [W-1:0] lo,
    output logic signed [W-1:0] hi
);
    localparam logic signed [W-1:0] POS_TOP = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] NEG_TOP = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0] mn;
    logic signed [W-1:0] mx;

    // Extreme registers: cleared by reset or cluster end, widened by hits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mn <= POS_TOP;
            mx <= NEG_TOP;
        end else if (hit_en) begin
            if (val < mn) mn <= val;
            if (val > mx) mx <= val;
        end
    end

    // Fold in the reference pixel at offset zero.
    always_comb begin
        lo = (mn < 0) ? mn : '0;
        hi = (mx > 0) ? mx : '0;
    end

    AST_EXTENT_ORDER: assert property (@(posedge clk) disable iff (!rst_n) lo <= hi); // R5
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (lo == 0 && hi == 0)); // R9
endmodule

// File: rtl/cc_col_map.sv
`timescale 1ns/1ps
// Module cc_col_map: maps an absolute column index to its pixel-centre
// position in normalized units. The first and last column of each chip are
// wide; the rest are standard. Assumes OUT_W can hold the whole module span.
module cc_col_map #(
    parameter int COL_W       = 8,
    parameter int COLS_PER_FE = 18,
    parameter int OUT_W       = 12
) (
    input  logic [COL_W-1:0] idx,
    output logic [OUT_W-1:0] centre
);
    localparam int CHIP_SPAN = 2 * cc_pkg::EDGE_SPAN + (COLS_PER_FE - 2) * cc_pkg::STD_SPAN;

    logic [COL_W-1:0] chip;
    logic [COL_W-1:0] pos;
    logic             wide_px;
    logic [OUT_W-1:0] start;

    // Chip base plus in-chip offset, then half the pixel width.
    always_comb begin
        chip    = idx / COL_W'(COLS_PER_FE);
        pos     = idx % COL_W'(COLS_PER_FE);
        wide_px = (pos == '0) || (pos == COL_W'(COLS_PER_FE - 1));
        start   = OUT_W'(chip) * OUT_W'(CHIP_SPAN);
        if (pos != '0)
            start = start + OUT_W'(cc_pkg::EDGE_SPAN) + OUT_W'(pos - 1'b1) * OUT_W'(cc_pkg::STD_SPAN);
        centre  = start + (wide_px ? OUT_W'(cc_pkg::EDGE_SPAN / 2) : OUT_W'(cc_pkg::STD_SPAN / 2));
    end
endmodule

// File: rtl/cc_out_reg.sv
`timescale 1ns/1ps
// Module cc_out_reg: single-entry holding register for the summary word with
// a valid/ready output. Assumes load is raised only when the slot is free or
// is being emptied in the same cycle.
module cc_out_reg #(
    parameter int CC_W = 12,
    parameter int CR_W = 12,
    parameter int SC_W = 9,
    parameter int SR_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CC_W-1:0] d_ctr_col,
    input  logic [CR_W-1:0] d_ctr_row,
    input  logic [SC_W-1:0] d_size_col,
    input  logic [SR_W-1:0] d_size_row,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [CC_W-1:0] q_ctr_col,
    output logic [CR_W-1:0] q_ctr_row,
    output logic [SC_W-1:0] q_size_col,
    output logic [SR_W-1:0] q_size_row
);
    // Valid flag: set by a load, cleared when the consumer takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n)                      out_valid <= 1'b0;
        else if (load)                   out_valid <= 1'b1;
        else if (out_valid && out_ready) out_valid <= 1'b0;
    end

    // Payload: captured on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_ctr_col  <= '0;
            q_ctr_row  <= '0;
            q_size_col <= '0;
            q_size_row <= '0;
        end else if (load) begin
            q_ctr_col  <= d_ctr_col;
            q_ctr_row  <= d_ctr_row;
            q_size_col <= d_size_col;
            q_size_row <= d_size_row;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(q_ctr_col) && $stable(q_ctr_row) && $stable(q_size_col) && $stable(q_size_row))); // R8
    AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n) load |-> (!out_valid || out_ready)); // R8
endmodule

// File: rtl/cc_centroid_unit.sv
`timescale 1ns/1ps
// Module cc_centroid_unit: collapses one cluster (offset hits then a closing
// word with the absolute reference) into one word holding the bounding-box
// centre in normalized units and the extent in pixels. Assumes the offsets
// plus the reference stay inside the module.
module cc_centroid_unit #(
    parameter int  NUM_COLS    = 144,
    parameter int  NUM_ROWS    = 328,
    parameter int  COLS_PER_FE = 18,
    localparam int COL_W       = $clog2(NUM_COLS),
    localparam int ROW_W       = $clog2(NUM_ROWS),
    localparam int CHIP_SPAN   = 2 * cc_pkg::EDGE_SPAN + (COLS_PER_FE - 2) * cc_pkg::STD_SPAN,
    localparam int NC_W        = $clog2((NUM_COLS / COLS_PER_FE) * CHIP_SPAN + 1),
    localparam int NR_W        = $clog2(NUM_ROWS * cc_pkg::ROW_SPAN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_last,
    input  logic [COL_W-1:0] in_col,
    input  logic [ROW_W-1:0] in_row,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [NC_W-1:0]  out_ctr_col,
    output logic [NR_W-1:0]  out_ctr_row,
    output logic [COL_W:0]   out_size_col,
    output logic [ROW_W:0]   out_size_row
);
    logic hit_fire;
    logic end_fire;
    logic signed [COL_W-1:0] lo_col, hi_col;
    logic signed [ROW_W-1:0] lo_row, hi_row;
    logic [COL_W-1:0] abs_col [2];
    logic [ROW_W-1:0] abs_row [2];
    logic [NC_W-1:0]  cen_col [2];
    logic [NR_W-1:0]  cen_row [2];
    logic [NC_W:0]    sum_col;
    logic [NR_W:0]    sum_row;
    logic [NC_W-1:0]  d_ctr_col;
    logic [NR_W-1:0]  d_ctr_row;
    logic [COL_W:0]   d_size_col;
    logic [ROW_W:0]   d_size_row;

    // Input handshake: stall only while a finished word waits.
    always_comb begin
        in_ready = !out_valid || out_ready;
        hit_fire = in_valid && in_ready && !in_last;
        end_fire = in_valid && in_ready && in_last;
    end

    cc_extent_track #(.W(COL_W)) u_ext_col (
        .clk(clk), .rst_n(rst_n), .hit_en(hit_fire), .clr(end_fire),
        .val($signed(in_col)), .lo(lo_col), .hi(hi_col)
    );

    cc_extent_track #(.W(ROW_W)) u_ext_row (
        .clk(clk), .rst_n(rst_n), .hit_en(hit_fire), .clr(end_fire),
        .val($signed(in_row)), .lo(lo_row), .hi(hi_row)
    );

    // Absolute extremes: reference plus offset (0 = low edge, 1 = high edge).
    always_comb begin
        abs_col[0] = in_col + $unsigned(lo_col);
        abs_col[1] = in_col + $unsigned(hi_col);
        abs_row[0] = in_row + $unsigned(lo_row);
        abs_row[1] = in_row + $unsigned(hi_row);
    end

    // One pixel-centre mapper per box edge, on each axis.
    for (genvar g = 0; g < 2; g++) begin : g_edge
        cc_col_map #(.COL_W(COL_W), .COLS_PER_FE(COLS_PER_FE), .OUT_W(NC_W)) u_col_map (
            .idx(abs_col[g]), .centre(cen_col[g])
        );
        assign cen_row[g] = NR_W'(abs_row[g]) * NR_W'(cc_pkg::ROW_SPAN) + NR_W'(cc_pkg::ROW_SPAN / 2);
    end

    // Centroid as the mean of edge centres; extent as index span plus one.
    always_comb begin
        sum_col    = {1'b0, cen_col[0]} + {1'b0, cen_col[1]};
        sum_row    = {1'b0, cen_row[0]} + {1'b0, cen_row[1]};
        d_ctr_col  = sum_col[NC_W:1];
        d_ctr_row  = sum_row[NR_W:1];
        d_size_col = {1'b0, abs_col[1]} - {1'b0, abs_col[0]} + 1'b1;
        d_size_row = {1'b0, abs_row[1]} - {1'b0, abs_row[0]} + 1'b1;
    end

    cc_out_reg #(.CC_W(NC_W), .CR_W(NR_W), .SC_W(COL_W + 1), .SR_W(ROW_W + 1)) u_out (
        .clk(clk), .rst_n(rst_n), .load(end_fire),
        .d_ctr_col(d_ctr_col), .d_ctr_row(d_ctr_row),
        .d_size_col(d_size_col), .d_size_row(d_size_row),
        .out_ready(out_ready), .out_valid(out_valid),
        .q_ctr_col(out_ctr_col), .q_ctr_row(out_ctr_row),
        .q_size_col(out_size_col), .q_size_row(out_size_row)
    );

    AST_END_GIVES_WORD: assert property (@(posedge clk) disable iff (!rst_n) end_fire |=> out_valid); // R2
    AST_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (hit_fire && !out_valid) |=> !out_valid); // R2
    AST_ROW_GRID: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> ((out_ctr_row % NR_W'(cc_pkg::ROW_SPAN / 2)) == '0)); // R4
    AST_SIZE_POS: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_size_col != '0 && out_size_row != '0)); // R5
endmodule

// File: tb/cc_centroid_unit_tb.sv
`timescale 1ns/1ps
module cc_centroid_unit_tb;
    localparam int CPF = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
    logic [7:0] in_col = '0;
    logic [8:0] in_row = '0;
    logic in_ready, out_valid;
    logic [11:0] out_ctr_col, out_ctr_row;
    logic [8:0] out_size_col;
    logic [9:0] out_size_row;

    always #2.5 clk = ~clk;

    cc_centroid_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_last(in_last), .in_col(in_col), .in_row(in_row),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_ctr_col(out_ctr_col), .out_ctr_row(out_ctr_row),
        .out_size_col(out_size_col), .out_size_row(out_size_row)
    );

    int nchk = 0, nfail = 0, cyc = 0, nout = 0, nend = 0;
    string phase = "R1";
    bit bp_mode = 0, hold = 0, done = 0;

    // reference model state
    int m_lo_c = 0, m_hi_c = 0, m_lo_r = 0, m_hi_r = 0;
    bit exp_v = 0;
    int e_cc, e_cr, e_sc, e_sr;
    int last_cc, last_cr, last_sc, last_sr;
    bit p_hit = 0, p_end = 0, p_out = 0;
    int p_col, p_row;
    int qc[$], qr[$];

    function automatic int col_centre(int idx);
        int pos = 0;
        for (int i = 0; i < idx; i++)
            pos += ((i % CPF == 0) || (i % CPF == CPF - 1)) ? 24 : 16;
        return pos + (((idx % CPF == 0) || (idx % CPF == CPF - 1)) ? 12 : 8);
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // out_ready driver
    always @(negedge clk) begin
        #0.5;
        out_ready = hold ? 1'b0 : (bp_mode ? 1'($urandom % 2) : 1'b1);
    end

    // cycle-by-cycle model and comparison
    always begin
        @(negedge clk);
        cyc++;
        if (cyc > 150000 && !done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
        if (rst_n) begin
            if (p_out) begin
                exp_v = 0; nout++;
                last_cc = e_cc; last_cr = e_cr; last_sc = e_sc; last_sr = e_sr;
            end
            if (p_hit) begin
                if (p_col < m_lo_c) m_lo_c = p_col;
                if (p_col > m_hi_c) m_hi_c = p_col;
                if (p_row < m_lo_r) m_lo_r = p_row;
                if (p_row > m_hi_r) m_hi_r = p_row;
            end
            if (p_end) begin
                int a0, a1, b0, b1;
                a0 = p_col + m_lo_c; a1 = p_col + m_hi_c;
                b0 = p_row + m_lo_r; b1 = p_row + m_hi_r;
                e_cc = (col_centre(a0) + col_centre(a1)) / 2;
                e_cr = ((10 * b0 + 5) + (10 * b1 + 5)) / 2;
                e_sc = a1 - a0 + 1; e_sr = b1 - b0 + 1;
                exp_v = 1; nend++;
                m_lo_c = 0; m_hi_c = 0; m_lo_r = 0; m_hi_r = 0;
            end
            nchk++;
            if (out_valid !== exp_v || (exp_v && (out_ctr_col != e_cc || out_ctr_row != e_cr ||
                out_size_col != e_sc || out_size_row != e_sr))) begin
                nfail++;
                $display("FAIL %s cycle=%0d actual v=%0b c=%0d r=%0d sc=%0d sr=%0d expected v=%0b c=%0d r=%0d sc=%0d sr=%0d",
                         phase, cyc, out_valid, out_ctr_col, out_ctr_row, out_size_col, out_size_row,
                         exp_v, e_cc, e_cr, e_sc, e_sr);
            end
        end
        #1;
        if (rst_n) begin
            chk("R8 in_ready", int'(in_ready), int'(!exp_v || out_ready));
            p_out = out_valid && out_ready;
            p_hit = in_valid && in_ready && !in_last;
            p_end = in_valid && in_ready && in_last;
            p_col = in_last ? int'(in_col) : int'($signed(in_col));
            p_row = in_last ? int'(in_row) : int'($signed(in_row));
        end else begin
            p_out = 0; p_hit = 0; p_end = 0;
        end
    end

    task automatic send(bit last, int c, int r);
        bit ok;
        in_valid = 1; in_last = last; in_col = c[7:0]; in_row = r[8:0];
        do begin
            #1; ok = in_ready;
            @(negedge clk); #0.5;
        end while (!ok);
        in_valid = 0;
    endtask

    // send queued offsets then the closing word, wait for the summary
    task automatic cluster(int rc, int rr);
        int n0 = nout;
        while (qc.size() > 0) send(0, qc.pop_front(), qr.pop_front());
        send(1, rc, rr);
        while (nout == n0) @(negedge clk);
        #0.5;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #0.5;
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        rst_n = 1;
        @(negedge clk); #0.5;

        phase = "R6";
        cluster(0, 0);
        chk("R6 ctr_col", last_cc, 12); chk("R6 ctr_row", last_cr, 5);
        chk("R6 size_col", last_sc, 1); chk("R6 size_row", last_sr, 1);

        phase = "R3";
        qc = '{1, 2}; qr = '{0, 0};
        cluster(1, 0);
        chk("R3 ctr_col std", last_cc, 48); chk("R5 size_col", last_sc, 3);
        qc = '{1}; qr = '{0};
        cluster(17, 0);
        chk("R3 ctr_col chip edge", last_cc, 304); chk("R5 size_col edge", last_sc, 2);

        phase = "R4";
        qc = '{0}; qr = '{4};
        cluster(5, 10);
        chk("R4 ctr_row", last_cr, 125); chk("R5 size_row", last_sr, 5);

        phase = "R7";
        qc = '{-2, -1}; qr = '{-3, 0};
        cluster(20, 50);
        chk("R7 ctr_col", last_cc, 334); chk("R7 ctr_row", last_cr, 490);
        chk("R7 size_col", last_sc, 3); chk("R7 size_row", last_sr, 4);

        phase = "R9";
        qc = '{5, -5}; qr = '{7, -7};
        cluster(60, 100);
        cluster(60, 100);
        chk("R9 size_col", last_sc, 1); chk("R9 size_row", last_sr, 1);
        chk("R9 ctr_row", last_cr, 1005);

        phase = "R8";
        hold = 1;
        @(negedge clk); #0.5;
        send(1, 30, 30);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 held valid", int'(out_valid), 1);
        chk("R8 stalled in_ready", int'(in_ready), 0);
        hold = 0;
        while (out_valid) @(negedge clk);
        #0.5;

        phase = "R2";
        bp_mode = 1;
        for (int k = 0; k < 300; k++) begin
            int nh = $urandom % 6;
            for (int h = 0; h < nh; h++) begin
                qc.push_back(int'($urandom % 7) - 3);
                qr.push_back(int'($urandom % 9) - 4);
            end
            cluster(4 + int'($urandom % 136), 4 + int'($urandom % 320));
        end
        bp_mode = 0;
        repeat (3) @(negedge clk);
        #0.5;
        chk("R2 one word per cluster", nout, nend);
        chk("R2 no pending word", int'(out_valid), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule